// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital sequencer behind a 10-bit successive-approximation analog-to-digital converter in a microcontroller. Software writes a control word with an enable bit, a start bit, a 4-bit input channel code and a 2-bit reference choice. The block drives the analog multiplexer select and the reference selects. It then runs a fixed sampling window and a binary search. During the search it presents a trial code to an external DAC and reads back a single comparator bit.

When the search ends, the block stores the right-justified result in a high and a low result byte. In the same cycle it drops its busy indication and raises a sticky interrupt flag. A write that clears the enable bit abandons a running conversion, and so does a reset. The block runs on a single clock. The integrator may feed it from a free-running internal RC oscillator so that conversions go on while the main clock is stopped.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset, busy, interrupt flag, enable state, channel select, both reference selects, trial code and both result bytes are all 0.
- R2: A control write with start=1 begins a conversion only if the same write sets enable=1 and no conversion is running. A start with enable=0, or a start while busy, has no effect.
- R3: The channel code is a binary input index (0 selects input 0, 15 selects input 15). When parameter NUM_CH is below 16, a write of a code at or above NUM_CH leaves the channel select unchanged.
- R4: Reference field bit 0 selects the positive reference: 0 is the supply, 1 is the external pin (vref_pos_ext). Bit 1 selects the negative reference: 0 is ground, 1 is the external pin (vref_neg_ext).
- R5: When a conversion completes, the result bytes load, busy falls and the interrupt flag rises, all on the same clock edge. The result bytes change at no other time except reset.
- R6: Busy stays high for exactly SAMPLE_CYC + 10 clock cycles after the cycle in which a start is accepted.
- R7: The trial code is 0 while idle or sampling. In step k (k = 9 down to 0) it holds the bits already decided above k, with bit k set. A comparator value of 1 at the end of the step keeps bit k, and 0 clears it.
- R8: Channel and reference fields in a write made while busy are ignored. The selects keep their values until the conversion ends.
- R9: The result is right-justified. res_hi[1:0] holds result bits 9:8, res_hi[7:2] is 0, and res_lo holds bits 7:0.
- R10: The interrupt flag stays set until flag_clr is high on an edge. A flag_clr on the completion edge loses, so the flag is set afterwards.
- R11: A control write with enable=0 during a conversion aborts it on that edge. Busy falls, and neither the result bytes nor the flag change.
- R12: A reset during a conversion aborts it and returns the result bytes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_we | input | 1 | Control word write strobe |
| wr_start | input | 1 | Start request bit of the written word |
| wr_en | input | 1 | Enable bit of the written word |
| wr_chan | input | CH_W | Channel code of the written word |
| wr_ref | input | 2 | Reference choice of the written word |
| flag_clr | input | 1 | Clears the interrupt flag |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the trial level |
| adc_on | output | 1 | Current enable state |
| busy | output | 1 | Conversion in progress |
| chan_sel | output | CH_W | Analog multiplexer select |
| vref_pos_ext | output | 1 | Positive reference from external pin |
| vref_neg_ext | output | 1 | Negative reference from external pin |
| trial_code | output | RES_BITS | Code to the external DAC |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |
| irq_flag | output | 1 | Conversion-complete interrupt flag |

## Verification
The analog inputs are modelled as fixed codes per channel, with a comparator that reports input at or above the trial code. Codes 0 and 1023 force every step to the same decision. Alternating patterns such as 0x155 and 0x2AA make each step decide the opposite way from the one before. The pair 511/512 differs only in the MSB decision and in all of the lower bits. Converting on channels 0, 1, 3, 12 and 15 shows that the select routing is correct, and that a mix-up of the high and low result bytes or a lost low bit is caught. Separate runs cover starts while disabled, starts while busy, aborts, a reset during a conversion, a flag clear that coincides with completion, and a reduced-channel instance that rejects codes it lacks.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_STEP   = 2'd2
   } adc_phase_e;
endpackage

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs #(
   parameter int CH_W   = 4,
   parameter int NUM_CH = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_we,
   input  logic            wr_en,
   input  logic [CH_W-1:0] wr_chan,
   input  logic [1:0]      wr_ref,
   input  logic            busy,
   output logic            en_q,
   output logic [CH_W-1:0] chan_q,
   output logic [1:0]      ref_q
);
   localparam int FULL_CH = 1 << CH_W;

   logic chan_ok;

   generate
      if (NUM_CH == FULL_CH) begin : g_all_ch
         assign chan_ok = 1'b1;
      end else begin : g_part_ch
         assign chan_ok = ({1'b0, wr_chan} < (CH_W + 1)'(NUM_CH));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         chan_q <= '0;
         ref_q  <= 2'b00;
      end else if (wr_we) begin
         en_q <= wr_en;
         if (!busy) begin
            ref_q <= wr_ref;
            if (chan_ok) chan_q <= wr_chan;
         end
      end
   end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
   import adc_sar_pkg::*;
#(
   parameter int RES_BITS   = 10,
   parameter int SAMPLE_CYC = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                abort,
   input  logic                cmp_hi,
   output logic                busy,
   output logic                done,
   output logic [RES_BITS-1:0] trial,
   output logic [RES_BITS-1:0] code_now
);
   localparam int BI_W = $clog2(RES_BITS);
   localparam int SC_W = $clog2(SAMPLE_CYC + 1);

   adc_phase_e          phase;
   logic [SC_W-1:0]     smp_cnt;
   logic [BI_W-1:0]     bit_idx;
   logic [RES_BITS-1:0] sar;
   logic [RES_BITS-1:0] mask;

   assign mask     = {{(RES_BITS-1){1'b0}}, 1'b1} << bit_idx;
   assign trial    = (phase == PH_STEP) ? (sar | mask) : '0;
   assign code_now = cmp_hi ? trial : sar;
   assign busy     = (phase != PH_IDLE);
   assign done     = (phase == PH_STEP) && (bit_idx == '0) && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         smp_cnt <= '0;
         bit_idx <= '0;
         sar     <= '0;
      end else if (abort) begin
         phase <= PH_IDLE;
         sar   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase   <= PH_SAMPLE;
                  smp_cnt <= '0;
                  sar     <= '0;
               end
            end
            PH_SAMPLE: begin
               if (smp_cnt == SC_W'(SAMPLE_CYC - 1)) begin
                  phase   <= PH_STEP;
                  bit_idx <= BI_W'(RES_BITS - 1);
               end else begin
                  smp_cnt <= smp_cnt + SC_W'(1);
               end
            end
            PH_STEP: begin
               sar <= code_now;
               if (bit_idx == '0) phase <= PH_IDLE;
               else               bit_idx <= bit_idx - BI_W'(1);
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
   parameter int RES_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic [RES_BITS-1:0] code,
   input  logic                flag_clr,
   output logic [7:0]          res_hi,
   output logic [7:0]          res_lo,
   output logic                flag
);
   logic [15:0] pad;

   assign pad = 16'(code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hi <= 8'h00;
         res_lo <= 8'h00;
         flag   <= 1'b0;
      end else begin
         if (done) begin
            res_hi <= pad[15:8];
            res_lo <= pad[7:0];
         end
         if (done)          flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl #(
   parameter int RES_BITS   = 10,
   parameter int CH_W       = 4,
   parameter int NUM_CH     = 16,
   parameter int SAMPLE_CYC = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_we,
   input  logic                wr_start,
   input  logic                wr_en,
   input  logic [CH_W-1:0]     wr_chan,
   input  logic [1:0]          wr_ref,
   input  logic                flag_clr,
   input  logic                cmp_hi,
   output logic                adc_on,
   output logic                busy,
   output logic [CH_W-1:0]     chan_sel,
   output logic                vref_pos_ext,
   output logic                vref_neg_ext,
   output logic [RES_BITS-1:0] trial_code,
   output logic [7:0]          res_hi,
   output logic [7:0]          res_lo,
   output logic                irq_flag
);
   generate
      if (RES_BITS < 9 || RES_BITS > 16) begin : g_bad_res
         $error("RES_BITS must lie in 9..16");
      end
      if (NUM_CH < 1 || NUM_CH > (1 << CH_W)) begin : g_bad_ch
         $error("NUM_CH must lie in 1..2**CH_W");
      end
      if (SAMPLE_CYC < 1) begin : g_bad_smp
         $error("SAMPLE_CYC must be at least 1");
      end
   endgenerate

   logic                start_ok;
   logic                abort;
   logic                done;
   logic [RES_BITS-1:0] code_now;
   logic [1:0]          ref_q;

   assign start_ok = wr_we && wr_start && wr_en && !busy;
   assign abort    = wr_we && !wr_en && busy;

   adc_ctl_regs #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_we   (wr_we),
      .wr_en   (wr_en),
      .wr_chan (wr_chan),
      .wr_ref  (wr_ref),
      .busy    (busy),
      .en_q    (adc_on),
      .chan_q  (chan_sel),
      .ref_q   (ref_q)
   );

   assign vref_pos_ext = ref_q[0];
   assign vref_neg_ext = ref_q[1];

   adc_sar_seq #(.RES_BITS(RES_BITS), .SAMPLE_CYC(SAMPLE_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_ok),
      .abort    (abort),
      .cmp_hi   (cmp_hi),
      .busy     (busy),
      .done     (done),
      .trial    (trial_code),
      .code_now (code_now)
   );

   adc_result_regs #(.RES_BITS(RES_BITS)) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .code     (code_now),
      .flag_clr (flag_clr),
      .res_hi   (res_hi),
      .res_lo   (res_lo),
      .flag     (irq_flag)
   );
endmodule

// File: rtl/adc_sar_ctrl_chk.sv
module adc_sar_ctrl_chk #(
   parameter int RES_BITS   = 10,
   parameter int CH_W       = 4,
   parameter int NUM_CH     = 16,
   parameter int SAMPLE_CYC = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                flag_clr,
   input logic                adc_on,
   input logic                busy,
   input logic [CH_W-1:0]     chan_sel,
   input logic [RES_BITS-1:0] trial_code,
   input logic [7:0]          res_hi,
   input logic [7:0]          res_lo,
   input logic                irq_flag
);
   logic [15:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 16'd1;
      else           busy_len <= '0;
   end

   // R5: flag rises only on the completion edge
   p_flag_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $fell(busy));

   // R5: result bytes move only when a conversion ends
   p_res_only_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({res_hi, res_lo}) |-> $fell(busy));

   // R6: a completed conversion lasts the sample window plus one step per bit
   p_conv_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && adc_on) |-> (busy_len == 16'(SAMPLE_CYC + RES_BITS)));

   // R7: no trial code outside a conversion
   p_trial_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (trial_code == '0));

   // R8: channel held during a conversion
   p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(chan_sel));

   // R3: only implemented channel codes appear
   p_chan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, chan_sel} < (CH_W + 1)'(NUM_CH)));

   // R10: flag sticky until cleared
   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_flag) && !$past(flag_clr)) |-> irq_flag);

   // R11: abort sets no flag
   p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !adc_on) |-> !$rose(irq_flag));
endmodule

bind adc_sar_ctrl adc_sar_ctrl_chk #(
   .RES_BITS(RES_BITS), .CH_W(CH_W), .NUM_CH(NUM_CH), .SAMPLE_CYC(SAMPLE_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flag_clr   (flag_clr),
   .adc_on     (adc_on),
   .busy       (busy),
   .chan_sel   (chan_sel),
   .trial_code (trial_code),
   .res_hi     (res_hi),
   .res_lo     (res_lo),
   .irq_flag   (irq_flag)
);

// File: tb/sim_adc_sar_ctrl.sv
module sim_adc_sar_ctrl;
   localparam int S  = 4;
   localparam int RB = 10;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       wr_we = 1'b0, wr_start = 1'b0, wr_en = 1'b0, flag_clr = 1'b0;
   logic [3:0] wr_chan = '0;
   logic [1:0] wr_ref = '0;
   logic       cmp0, cmp1;
   logic       adc_on, busy, vpos, vneg, irq_flag;
   logic [3:0] chan_sel;
   logic [9:0] trial_code;
   logic [7:0] res_hi, res_lo;
   logic       a1_on, a1_busy, a1_vp, a1_vn, a1_irq;
   logic [3:0] a1_chan;
   logic [9:0] a1_trial;
   logic [7:0] a1_hi, a1_lo;

   logic [9:0] vin [16];

   assign cmp0 = (vin[chan_sel] >= trial_code);
   assign cmp1 = (vin[a1_chan] >= a1_trial);

   adc_sar_ctrl #(.RES_BITS(RB), .CH_W(4), .NUM_CH(16), .SAMPLE_CYC(S)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_we(wr_we), .wr_start(wr_start), .wr_en(wr_en),
      .wr_chan(wr_chan), .wr_ref(wr_ref), .flag_clr(flag_clr), .cmp_hi(cmp0),
      .adc_on(adc_on), .busy(busy), .chan_sel(chan_sel), .vref_pos_ext(vpos),
      .vref_neg_ext(vneg), .trial_code(trial_code), .res_hi(res_hi), .res_lo(res_lo),
      .irq_flag(irq_flag));

   adc_sar_ctrl #(.RES_BITS(RB), .CH_W(4), .NUM_CH(12), .SAMPLE_CYC(S)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_we(wr_we), .wr_start(wr_start), .wr_en(wr_en),
      .wr_chan(wr_chan), .wr_ref(wr_ref), .flag_clr(flag_clr), .cmp_hi(cmp1),
      .adc_on(a1_on), .busy(a1_busy), .chan_sel(a1_chan), .vref_pos_ext(a1_vp),
      .vref_neg_ext(a1_vn), .trial_code(a1_trial), .res_hi(a1_hi), .res_lo(a1_lo),
      .irq_flag(a1_irq));

   int nvec = 0;
   int nfail = 0;

   task automatic chk(input string req, input string what, input int got, input int exp);
      nvec++;
      if (got != exp) begin
         nfail++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   // behavioural reference model
   bit         m_busy, m_flag, m_on;
   int         m_left;
   logic [3:0] m_chan, m_chan1;
   logic [1:0] m_ref;
   logic [9:0] m_res;

   always @(posedge clk or negedge rst_n) begin
      bit was_busy, done;
      if (!rst_n) begin
         m_busy = 0; m_flag = 0; m_on = 0; m_left = 0;
         m_chan = 0; m_chan1 = 0; m_ref = 0; m_res = 0;
      end else begin
         was_busy = m_busy;
         done = 0;
         if (m_busy) begin
            if (wr_we && !wr_en) m_busy = 0;
            else begin
               m_left--;
               if (m_left == 0) begin
                  m_busy = 0; done = 1; m_res = vin[m_chan];
               end
            end
         end
         if (wr_we) begin
            m_on = wr_en;
            if (!was_busy) begin
               m_ref = wr_ref;
               m_chan = wr_chan;
               if (wr_chan < 12) m_chan1 = wr_chan;
            end
         end
         if (!was_busy && wr_we && wr_start && wr_en) begin
            m_busy = 1; m_left = S + RB;
         end
         if (done) m_flag = 1;
         else if (flag_clr) m_flag = 0;
      end
   end

   always @(negedge clk) begin
      int exp_trial;
      exp_trial = 0;
      if (m_busy && m_left <= RB)
         exp_trial = ((int'(vin[m_chan]) >> m_left) << m_left) | (1 << (m_left - 1));
      chk("R6", "busy", busy, m_busy);
      chk("R10", "irq_flag", irq_flag, m_flag);
      chk("R2", "adc_on", adc_on, m_on);
      chk("R8", "chan_sel", chan_sel, m_chan);
      chk("R3", "u1 chan_sel", a1_chan, m_chan1);
      chk("R4", "vref_pos_ext", vpos, m_ref[0]);
      chk("R4", "vref_neg_ext", vneg, m_ref[1]);
      chk("R7", "trial_code", trial_code, exp_trial);
      chk("R5", "res_hi", res_hi, m_res[9:8]);
      chk("R5", "res_lo", res_lo, m_res[7:0]);
   end

   task automatic wr(input bit st, input bit en, input int ch, input int rf);
      @(negedge clk); #1;
      wr_we = 1; wr_start = st; wr_en = en; wr_chan = 4'(ch); wr_ref = 2'(rf);
      @(negedge clk); #1;
      wr_we = 0; wr_start = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic convert(input int ch);
      wr(1, 1, ch, 0);
      idle(S + RB + 2);
      chk("R9", "res_hi upper", int'(res_hi), int'(vin[ch]) >> 8);
      chk("R9", "res_lo", int'(res_lo), int'(vin[ch]) & 255);
      chk("R5", "flag after done", irq_flag, 1);
      wr(0, 1, ch, 0);
      flag_clr = 1; idle(1); flag_clr = 0;
   endtask

   bit fin = 0;

   initial begin
      for (int i = 0; i < 16; i++) vin[i] = 10'((i * 97 + 31) % 1024);
      vin[0] = 10'd0;   vin[1] = 10'd1023; vin[2] = 10'd512;
      vin[3] = 10'h155; vin[4] = 10'd511;  vin[12] = 10'h2AA; vin[15] = 10'd1;
      idle(3);
      rst_n = 1;
      idle(1);
      // R1 reset state
      chk("R1", "busy", busy, 0);
      chk("R1", "irq", irq_flag, 0);
      chk("R1", "res", {res_hi, res_lo}, 0);
      chk("R1", "trial", trial_code, 0);
      // R4 reference selects
      wr(0, 1, 2, 1); chk("R4", "pos ext", vpos, 1); chk("R4", "neg ext", vneg, 0);
      wr(0, 1, 2, 2); chk("R4", "pos ext", vpos, 0); chk("R4", "neg ext", vneg, 1);
      // main function on several channels
      convert(2); convert(0); convert(1); convert(3);
      convert(4); convert(12); convert(15);
      // R2: start while disabled
      wr(1, 0, 1, 0); idle(2);
      chk("R2", "busy after disabled start", busy, 0);
      // R8 / R2: writes while busy
      wr(1, 1, 3, 0);
      wr(1, 1, 5, 3);
      chk("R8", "chan kept while busy", chan_sel, 3);
      chk("R8", "ref kept while busy", vpos, 0);
      idle(S + RB + 2);
      chk("R2", "no restart", busy, 0);
      chk("R5", "result of ch3", {res_hi, res_lo}, vin[3]);
      // R10: clear coinciding with completion
      flag_clr = 1; idle(1); flag_clr = 0;
      chk("R10", "cleared", irq_flag, 0);
      wr(1, 1, 12, 0);
      repeat (S + 9) @(negedge clk);
      #1 flag_clr = 1;
      @(negedge clk); #1 flag_clr = 0;
      chk("R10", "set wins over clear", irq_flag, 1);
      flag_clr = 1; idle(1); flag_clr = 0;
      // R11 abort by disable
      wr(1, 1, 1, 0);
      idle(5);
      wr(0, 0, 1, 0);
      chk("R11", "busy after abort", busy, 0);
      idle(S + RB + 2);
      chk("R11", "flag after abort", irq_flag, 0);
      chk("R11", "result kept", {res_hi, res_lo}, vin[12]);
      // R3 reduced-channel instance
      wr(0, 1, 9, 0);
      wr(0, 1, 13, 0);
      chk("R3", "u1 rejects 13", a1_chan, 9);
      chk("R3", "u0 takes 13", chan_sel, 13);
      // R12 reset mid-conversion
      wr(1, 1, 1, 0);
      idle(6);
      rst_n = 0; idle(2);
      chk("R12", "busy in reset", busy, 0);
      chk("R12", "result cleared", {res_hi, res_lo}, 0);
      rst_n = 1; idle(S + RB + 2);
      chk("R12", "no late completion", irq_flag, 0);
      fin = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         nfail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end
endmodule